// File: doc/BRIEF.md
# Subsleep Power Mode Controller

This block sequences a microcontroller core into and out of a low-power subsleep mode. A one-cycle strobe from the core's sleep instruction asks it to enter the mode. The controller then checks three configuration bits. Only one combination leads to subsleep. Any other combination is reported back on a mode-request output, and the core stays active.

While in subsleep, the controller gates off the clock enables for the CPU and for the general peripherals. It keeps the clock enables running for four timer channels and two watchdog timers. It also asks for a reset of the serial, ADC and PWM peripherals, because their state is not kept in this mode.

The controller watches three kinds of wake source:
- The NMI input, which cannot be masked.
- Eight external interrupt lines, each gated by its own enable bit.
- A vector of peripheral interrupts, each gated by an enable bit and a CPU mask bit.

When a wake source qualifies, the core returns to the active state and gets a one-cycle exception-start pulse. Two reset pins and a standby pin are synchronized through two flops. They take priority over interrupts: the standby pin first, then the reset pins.

Top module: `subsleep_pmc`

## Requirements
- R1: From ACTIVE, a `sleep_stb` pulse with `cfg_stby_sel`=0, `cfg_lowspd`=1 and `cfg_wdt_sub`=1 moves the block to SUBSLEEP at the next clock edge. The `state_o` encoding is 0=ACTIVE, 1=SUBSLEEP, 2=HW_STANDBY, 3=RESET.
- R2: A `sleep_stb` pulse in ACTIVE with any other bit combination has the following effect:
  - The block stays in ACTIVE.
  - `mode_req` takes {`cfg_stby_sel`,`cfg_lowspd`,`cfg_wdt_sub`}, with bit 2 being `cfg_stby_sel`.
  - `mode_req_vld` pulses for exactly one cycle.
- R3: The clock enables depend on the state:
  - In ACTIVE, all clock enables are high.
  - In SUBSLEEP, `cpu_clk_en` and `oth_clk_en` are low, while every bit of `tmr_clk_en` and `wdt_clk_en` stays high.
  - In HW_STANDBY and RESET, all clock enables are low.
- R4: `periph_rst_req` has all three bits high exactly while the state is SUBSLEEP, and zero otherwise.
- R5: In SUBSLEEP, any of the following moves the block to ACTIVE at the next edge, with `exc_start` high for exactly that one cycle:
  - `nmi` high, whatever the enables and masks are.
  - An `irq` bit high whose `irq_en` bit is 1.
  - A `pirq` bit high whose `pirq_en` bit is 1 and whose `pirq_mask` bit is 0.
- R6: In SUBSLEEP, the following do not wake the block and do not pulse `exc_start`:
  - An `irq` bit whose enable is 0.
  - A `pirq` bit whose enable is 0 or whose mask bit is 1.
- R7: A low level on `stby_n` moves the block to HW_STANDBY at the third clock edge after the change, because of two synchronizer flops plus the state register. This holds whatever the reset pins and interrupts do in that cycle, and no `exc_start` pulse is produced.
- R8: A low level on `hard_rst_n` or `soft_rst_n` moves the block to RESET at the third edge after the change, taking priority over an interrupt in the same cycle. While in RESET, `core_rst` is high and `sleep_stb` is ignored.
- R9: From HW_STANDBY, `stby_n` returning high leads to RESET at the third edge. From RESET, the block goes to ACTIVE at the first edge at which both synchronized reset pins are high.
- R10: While `rst` is high, the block is held in RESET with `core_rst`=1, all clock enables 0 and `mode_req_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_stb | input | 1 | One-cycle sleep-instruction strobe |
| cfg_stby_sel | input | 1 | Standby-select configuration bit |
| cfg_lowspd | input | 1 | Low-speed-on configuration bit |
| cfg_wdt_sub | input | 1 | Watchdog prescaler-select configuration bit |
| nmi | input | 1 | Non-maskable interrupt |
| irq | input | N_IRQ | External interrupt lines |
| irq_en | input | N_IRQ | Per-line external interrupt enables |
| pirq | input | N_PIRQ | Peripheral interrupt requests |
| pirq_en | input | N_PIRQ | Peripheral interrupt enables |
| pirq_mask | input | N_PIRQ | CPU mask per peripheral interrupt (1 = blocked) |
| hard_rst_n | input | 1 | Asynchronous reset pin, active low |
| soft_rst_n | input | 1 | Second asynchronous reset pin, active low |
| stby_n | input | 1 | Hardware standby pin, active low |
| cpu_clk_en | output | 1 | CPU clock enable |
| oth_clk_en | output | 1 | Clock enable for general peripherals |
| tmr_clk_en | output | N_TMR | Timer-channel clock enables |
| wdt_clk_en | output | N_WDT | Watchdog clock enables |
| periph_rst_req | output | N_RREQ | Reset request for serial, ADC and PWM |
| exc_start | output | 1 | One-cycle interrupt-exception-start pulse |
| mode_req | output | 3 | Last non-subsleep configuration seen with a strobe |
| mode_req_vld | output | 1 | One-cycle pulse marking a new `mode_req` |
| core_rst | output | 1 | Core held in reset |
| state_o | output | 2 | Current state |

## Verification
In SUBSLEEP, a qualifying interrupt can land in the same cycle as a synchronized standby-pin or reset-pin event.

To provoke this, the bench drives the pin low and waits two edges. It confirms that the block is still in SUBSLEEP, then raises `nmi` just before the edge at which the synchronized pin reaches the state register.

It judges the result by the state after that edge: HW_STANDBY, or RESET when only a reset pin was driven. It also checks that `exc_start` stayed low.

The wake-qualification logic is covered by a table of enable and mask patterns, each with its expected wake outcome.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE   = 2'd0,
    ST_SUBSLEEP = 2'd1,
    ST_HWSTBY   = 2'd2,
    ST_RESET    = 2'd3
  } pmc_state_e;

  // {stby_sel, lowspd, wdt_sub} pattern that permits subsleep entry
  localparam logic [2:0] CFG_SUB_ENTRY = 3'b011;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int WIDTH   = 1,
  parameter int STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= {WIDTH{RST_VAL}};
    else     chain_q[0] <= d_async;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= {WIDTH{RST_VAL}};
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_wake_qual.sv
module pmc_wake_qual #(
  parameter int N_IRQ  = 8,
  parameter int N_PIRQ = 8
) (
  input  logic              nmi,
  input  logic [N_IRQ-1:0]  irq,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic [N_PIRQ-1:0] pirq,
  input  logic [N_PIRQ-1:0] pirq_en,
  input  logic [N_PIRQ-1:0] pirq_mask,
  output logic              wake
);
  logic [N_IRQ-1:0]  irq_hit;
  logic [N_PIRQ-1:0] pirq_hit;

  generate
    for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      assign irq_hit[i] = irq[i] & irq_en[i];
    end
    for (genvar p = 0; p < N_PIRQ; p++) begin : g_pirq
      assign pirq_hit[p] = pirq[p] & pirq_en[p] & ~pirq_mask[p];
    end
  endgenerate

  // NMI bypasses all gating
  assign wake = nmi | (|irq_hit) | (|pirq_hit);
endmodule

// File: rtl/pmc_clkgate.sv
module pmc_clkgate
  import pmc_pkg::*;
#(
  parameter int N_TMR  = 4,
  parameter int N_WDT  = 2,
  parameter int N_RREQ = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  pmc_state_e        st_next,
  output logic              cpu_clk_en,
  output logic              oth_clk_en,
  output logic [N_TMR-1:0]  tmr_clk_en,
  output logic [N_WDT-1:0]  wdt_clk_en,
  output logic [N_RREQ-1:0] periph_rst_req,
  output logic              core_rst
);
  logic run_all, run_keep, in_sub;

  assign run_all  = (st_next == ST_ACTIVE);
  assign in_sub   = (st_next == ST_SUBSLEEP);
  assign run_keep = run_all | in_sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en <= 1'b0;
      oth_clk_en <= 1'b0;
      core_rst   <= 1'b1;
    end else begin
      cpu_clk_en <= run_all;
      oth_clk_en <= run_all;
      core_rst   <= (st_next == ST_RESET);
    end
  end

  generate
    for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      always_ff @(posedge clk) begin
        if (rst) tmr_clk_en[t] <= 1'b0;
        else     tmr_clk_en[t] <= run_keep;
      end
    end
    for (genvar w = 0; w < N_WDT; w++) begin : g_wdt
      always_ff @(posedge clk) begin
        if (rst) wdt_clk_en[w] <= 1'b0;
        else     wdt_clk_en[w] <= run_keep;
      end
    end
    for (genvar r = 0; r < N_RREQ; r++) begin : g_rreq
      always_ff @(posedge clk) begin
        if (rst) periph_rst_req[r] <= 1'b0;
        else     periph_rst_req[r] <= in_sub;
      end
    end
  endgenerate

  // R3: CPU clock never runs while the kept domains are stopped
  a_r3_cpu_implies_keep: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> (&tmr_clk_en && &wdt_clk_en));
  // R4: reset request only while CPU stopped and kept domains run
  a_r4_rreq_only_sub: assert property (@(posedge clk) disable iff (rst)
    (|periph_rst_req) |-> (!cpu_clk_en && !oth_clk_en && &tmr_clk_en));
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleep_stb,
  input  logic [2:0] cfg_bits,
  input  logic       wake,
  input  logic       stby_ok,
  input  logic       rst_req,
  output pmc_state_e st_q,
  output pmc_state_e st_next,
  output logic       exc_start,
  output logic [2:0] mode_req,
  output logic       mode_req_vld
);
  logic cfg_ok;
  logic exc_d, req_d;

  assign cfg_ok = (cfg_bits == CFG_SUB_ENTRY);

  always_comb begin
    st_next = st_q;
    exc_d   = 1'b0;
    req_d   = 1'b0;
    unique case (st_q)
      ST_ACTIVE: begin
        if (!stby_ok)       st_next = ST_HWSTBY;
        else if (rst_req)   st_next = ST_RESET;
        else if (sleep_stb) begin
          if (cfg_ok) st_next = ST_SUBSLEEP;
          else        req_d   = 1'b1;
        end
      end
      ST_SUBSLEEP: begin
        if (!stby_ok)     st_next = ST_HWSTBY;
        else if (rst_req) st_next = ST_RESET;
        else if (wake) begin
          st_next = ST_ACTIVE;
          exc_d   = 1'b1;
        end
      end
      ST_HWSTBY: begin
        if (stby_ok) st_next = ST_RESET;
      end
      ST_RESET: begin
        if (!stby_ok)     st_next = ST_HWSTBY;
        else if (!rst_req) st_next = ST_ACTIVE;
      end
      default: st_next = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_RESET;
      exc_start    <= 1'b0;
      mode_req_vld <= 1'b0;
      mode_req     <= 3'b000;
    end else begin
      st_q         <= st_next;
      exc_start    <= exc_d;
      mode_req_vld <= req_d;
      if (req_d) mode_req <= cfg_bits;
    end
  end

  // R1: qualifying strobe enters subsleep
  a_r1_enter: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ACTIVE && sleep_stb && cfg_bits == 3'b011 && stby_ok && !rst_req)
      |=> st_q == ST_SUBSLEEP);
  // R2: other combinations keep the core active
  a_r2_stay: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_ACTIVE && sleep_stb && cfg_bits != 3'b011 && stby_ok && !rst_req)
      |=> (st_q == ST_ACTIVE && mode_req_vld));
  // R5: wake leaves subsleep with one exception pulse
  a_r5_wake: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SUBSLEEP && wake && stby_ok && !rst_req)
      |=> (st_q == ST_ACTIVE && exc_start));
  a_r5_pulse: assert property (@(posedge clk) disable iff (rst)
    exc_start |=> !exc_start);
  // R7: standby pin wins over everything
  a_r7_stby: assert property (@(posedge clk) disable iff (rst)
    (!stby_ok && st_q != ST_HWSTBY) |=> (st_q == ST_HWSTBY && !exc_start));
  // R8: reset pin wins over interrupt
  a_r8_rst: assert property (@(posedge clk) disable iff (rst)
    (stby_ok && rst_req && st_q != ST_HWSTBY) |=> (st_q == ST_RESET && !exc_start));
endmodule

// File: rtl/subsleep_pmc.sv
module subsleep_pmc
  import pmc_pkg::*;
#(
  parameter int N_IRQ       = 8,
  parameter int N_PIRQ      = 8,
  parameter int N_TMR       = 4,
  parameter int N_WDT       = 2,
  parameter int N_RREQ      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_stb,
  input  logic              cfg_stby_sel,
  input  logic              cfg_lowspd,
  input  logic              cfg_wdt_sub,
  input  logic              nmi,
  input  logic [N_IRQ-1:0]  irq,
  input  logic [N_IRQ-1:0]  irq_en,
  input  logic [N_PIRQ-1:0] pirq,
  input  logic [N_PIRQ-1:0] pirq_en,
  input  logic [N_PIRQ-1:0] pirq_mask,
  input  logic              hard_rst_n,
  input  logic              soft_rst_n,
  input  logic              stby_n,
  output logic              cpu_clk_en,
  output logic              oth_clk_en,
  output logic [N_TMR-1:0]  tmr_clk_en,
  output logic [N_WDT-1:0]  wdt_clk_en,
  output logic [N_RREQ-1:0] periph_rst_req,
  output logic              exc_start,
  output logic [2:0]        mode_req,
  output logic              mode_req_vld,
  output logic              core_rst,
  output logic [1:0]        state_o
);
  localparam int N_PINS = 3;

  logic [N_PINS-1:0] pins_s;
  logic              wake;
  logic              rst_req;
  pmc_state_e        st_q, st_next;

  pmc_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({stby_n, soft_rst_n, hard_rst_n}),
    .q_sync  (pins_s)
  );

  assign rst_req = ~pins_s[0] | ~pins_s[1];

  pmc_wake_qual #(.N_IRQ(N_IRQ), .N_PIRQ(N_PIRQ)) u_wake (
    .nmi       (nmi),
    .irq       (irq),
    .irq_en    (irq_en),
    .pirq      (pirq),
    .pirq_en   (pirq_en),
    .pirq_mask (pirq_mask),
    .wake      (wake)
  );

  pmc_seq u_seq (
    .clk          (clk),
    .rst          (rst),
    .sleep_stb    (sleep_stb),
    .cfg_bits     ({cfg_stby_sel, cfg_lowspd, cfg_wdt_sub}),
    .wake         (wake),
    .stby_ok      (pins_s[2]),
    .rst_req      (rst_req),
    .st_q         (st_q),
    .st_next      (st_next),
    .exc_start    (exc_start),
    .mode_req     (mode_req),
    .mode_req_vld (mode_req_vld)
  );

  pmc_clkgate #(.N_TMR(N_TMR), .N_WDT(N_WDT), .N_RREQ(N_RREQ)) u_clk (
    .clk            (clk),
    .rst            (rst),
    .st_next        (st_next),
    .cpu_clk_en     (cpu_clk_en),
    .oth_clk_en     (oth_clk_en),
    .tmr_clk_en     (tmr_clk_en),
    .wdt_clk_en     (wdt_clk_en),
    .periph_rst_req (periph_rst_req),
    .core_rst       (core_rst)
  );

  assign state_o = st_q;

  // R3: subsleep clock pattern seen at the ports
  a_r3_sub_clocks: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SUBSLEEP) |-> (!cpu_clk_en && !oth_clk_en && &tmr_clk_en && &wdt_clk_en));
  // R4: reset request tracks subsleep
  a_r4_rreq: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SUBSLEEP) == (&periph_rst_req));
  // R8: core reset output tracks RESET state
  a_r8_core_rst: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RESET) == core_rst);
endmodule

// File: tb/subsleep_pmc_tb.sv
module subsleep_pmc_tb_top;
  logic clk = 1'b0;
  logic rst;
  logic sleep_stb, cfg_stby_sel, cfg_lowspd, cfg_wdt_sub, nmi;
  logic [7:0] irq, irq_en, pirq, pirq_en, pirq_mask;
  logic hard_rst_n, soft_rst_n, stby_n;
  logic cpu_clk_en, oth_clk_en, exc_start, mode_req_vld, core_rst;
  logic [3:0] tmr_clk_en;
  logic [1:0] wdt_clk_en;
  logic [2:0] periph_rst_req;
  logic [2:0] mode_req;
  logic [1:0] state_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  subsleep_pmc dut_i (
    .clk(clk), .rst(rst), .sleep_stb(sleep_stb),
    .cfg_stby_sel(cfg_stby_sel), .cfg_lowspd(cfg_lowspd), .cfg_wdt_sub(cfg_wdt_sub),
    .nmi(nmi), .irq(irq), .irq_en(irq_en),
    .pirq(pirq), .pirq_en(pirq_en), .pirq_mask(pirq_mask),
    .hard_rst_n(hard_rst_n), .soft_rst_n(soft_rst_n), .stby_n(stby_n),
    .cpu_clk_en(cpu_clk_en), .oth_clk_en(oth_clk_en),
    .tmr_clk_en(tmr_clk_en), .wdt_clk_en(wdt_clk_en),
    .periph_rst_req(periph_rst_req), .exc_start(exc_start),
    .mode_req(mode_req), .mode_req_vld(mode_req_vld),
    .core_rst(core_rst), .state_o(state_o)
  );

  typedef struct packed {
    logic       nmi;
    logic [7:0] irq;
    logic [7:0] irq_en;
    logic [7:0] pirq;
    logic [7:0] pirq_en;
    logic [7:0] pirq_mask;
    logic       wake;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 1'b1},
    '{1'b0, 8'h04, 8'h04, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b0, 8'h04, 8'hFB, 8'h00, 8'h00, 8'h00, 1'b0},
    '{1'b0, 8'h80, 8'h80, 8'h00, 8'h00, 8'h00, 1'b1},
    '{1'b0, 8'h00, 8'h00, 8'h02, 8'h02, 8'h00, 1'b1},
    '{1'b0, 8'h00, 8'h00, 8'h02, 8'h02, 8'h02, 1'b0},
    '{1'b0, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 1'b0},
    '{1'b0, 8'h01, 8'h00, 8'h10, 8'h10, 8'hEF, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic enter_sub();
    sleep_stb = 1'b1; cfg_stby_sel = 1'b0; cfg_lowspd = 1'b1; cfg_wdt_sub = 1'b1;
    tick();
    sleep_stb = 1'b0;
  endtask

  task automatic clr_src();
    nmi = 1'b0; irq = '0; irq_en = '0; pirq = '0; pirq_en = '0; pirq_mask = '0;
  endtask

  task automatic chk_clocks(input string req, input bit cpu, input bit keep);
    chk(cpu_clk_en == cpu, req, "cpu_clk_en", int'(cpu_clk_en), int'(cpu));
    chk(oth_clk_en == cpu, req, "oth_clk_en", int'(oth_clk_en), int'(cpu));
    chk(tmr_clk_en == {4{keep}}, req, "tmr_clk_en", int'(tmr_clk_en), keep ? 15 : 0);
    chk(wdt_clk_en == {2{keep}}, req, "wdt_clk_en", int'(wdt_clk_en), keep ? 3 : 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sleep_stb = 1'b0; cfg_stby_sel = 1'b0; cfg_lowspd = 1'b0; cfg_wdt_sub = 1'b0;
    clr_src();
    hard_rst_n = 1'b1; soft_rst_n = 1'b1; stby_n = 1'b1;
    @(negedge clk);
    tick(); tick();
    // R10: reset state
    chk(state_o == 2'd3, "R10", "state in rst", state_o, 3);
    chk(core_rst == 1'b1, "R10", "core_rst", core_rst, 1);
    chk_clocks("R10", 1'b0, 1'b0);
    chk(mode_req_vld == 1'b0, "R10", "mode_req_vld", mode_req_vld, 0);
    rst = 1'b0;
    tick();
    // R9: RESET -> ACTIVE with pins released
    chk(state_o == 2'd0, "R9", "state after rst", state_o, 0);
    chk_clocks("R3", 1'b1, 1'b1);
    chk(periph_rst_req == 3'b000, "R4", "rreq active", periph_rst_req, 0);

    // R2: every non-entry combination
    for (int c = 0; c < 8; c++) begin
      if (c == 3) continue;
      sleep_stb = 1'b1;
      {cfg_stby_sel, cfg_lowspd, cfg_wdt_sub} = 3'(c);
      tick();
      sleep_stb = 1'b0;
      chk(state_o == 2'd0, "R2", "stay active", state_o, 0);
      chk(mode_req_vld == 1'b1, "R2", "vld pulse", mode_req_vld, 1);
      chk(mode_req == 3'(c), "R2", "mode_req", mode_req, c);
      tick();
      chk(mode_req_vld == 1'b0, "R2", "vld one cycle", mode_req_vld, 0);
    end

    // R1, R3, R4: entry and subsleep outputs
    enter_sub();
    chk(state_o == 2'd1, "R1", "enter", state_o, 1);
    chk_clocks("R3", 1'b0, 1'b1);
    chk(periph_rst_req == 3'b111, "R4", "rreq sub", periph_rst_req, 7);
    chk(mode_req_vld == 1'b0, "R1", "no vld on entry", mode_req_vld, 0);
    tick();
    chk(state_o == 2'd1, "R1", "hold sub", state_o, 1);

    // R5, R6: wake qualification table
    for (int v = 0; v < NV; v++) begin
      if (state_o != 2'd1) enter_sub();
      nmi = TBL[v].nmi; irq = TBL[v].irq; irq_en = TBL[v].irq_en;
      pirq = TBL[v].pirq; pirq_en = TBL[v].pirq_en; pirq_mask = TBL[v].pirq_mask;
      tick();
      clr_src();
      if (TBL[v].wake) begin
        chk(state_o == 2'd0, "R5", $sformatf("wake vec %0d", v), state_o, 0);
        chk(exc_start == 1'b1, "R5", $sformatf("exc vec %0d", v), exc_start, 1);
        chk(periph_rst_req == 3'b000, "R4", "rreq after wake", periph_rst_req, 0);
        tick();
        chk(exc_start == 1'b0, "R5", "exc one cycle", exc_start, 0);
      end else begin
        chk(state_o == 2'd1, "R6", $sformatf("no wake vec %0d", v), state_o, 1);
        chk(exc_start == 1'b0, "R6", $sformatf("no exc vec %0d", v), exc_start, 0);
      end
    end

    // R7: standby pin, reset pin and NMI in the same cycle
    if (state_o != 2'd1) enter_sub();
    stby_n = 1'b0; hard_rst_n = 1'b0;
    tick(); tick();
    chk(state_o == 2'd1, "R7", "sync latency", state_o, 1);
    nmi = 1'b1;
    tick();
    nmi = 1'b0;
    chk(state_o == 2'd2, "R7", "hw standby", state_o, 2);
    chk(exc_start == 1'b0, "R7", "no exc", exc_start, 0);
    chk_clocks("R3", 1'b0, 1'b0);
    // R9: standby release -> RESET (reset pin still low)
    stby_n = 1'b1;
    tick(); tick();
    chk(state_o == 2'd2, "R9", "stby exit latency", state_o, 2);
    tick();
    chk(state_o == 2'd3, "R9", "to reset", state_o, 3);
    chk(core_rst == 1'b1, "R8", "core_rst", core_rst, 1);
    // R8: sleep ignored in RESET
    sleep_stb = 1'b1; {cfg_stby_sel, cfg_lowspd, cfg_wdt_sub} = 3'b011;
    tick();
    sleep_stb = 1'b0;
    chk(state_o == 2'd3, "R8", "sleep ignored", state_o, 3);
    chk(mode_req_vld == 1'b0, "R8", "no vld in reset", mode_req_vld, 0);
    hard_rst_n = 1'b1;
    tick(); tick();
    chk(state_o == 2'd3, "R9", "reset hold", state_o, 3);
    tick();
    chk(state_o == 2'd0, "R9", "reset release", state_o, 0);

    // R8: reset pin beats NMI
    enter_sub();
    soft_rst_n = 1'b0;
    tick(); tick();
    chk(state_o == 2'd1, "R8", "sync latency", state_o, 1);
    nmi = 1'b1;
    tick();
    nmi = 1'b0;
    chk(state_o == 2'd3, "R8", "reset wins", state_o, 3);
    chk(exc_start == 1'b0, "R8", "no exc", exc_start, 0);
    soft_rst_n = 1'b1;
    tick(); tick(); tick();
    chk(state_o == 2'd0, "R9", "back active", state_o, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule